// File: doc/BRIEF.md
# Reference Qualification Timer

This block sits behind the health monitors that watch one input reference of a clock synchronizer. It receives three raw failure flags: a single-period check, a coarse frequency check and a fine frequency check. Each flag passes through a tick-based persistence filter, so a flag that sits near its monitor's threshold cannot make the status flicker. The filtered flags are merged into a reference-fail status. Only the single-period and coarse flags may push the loop into holdover.

The same two severe flags drive a qualification timer. Failure time adds up across separate episodes. A gap does not restart the count. The reference is disqualified once the total reaches a threshold. A disqualified reference returns to service only after a much longer unbroken clean stretch. Time is counted in a slow tick, so one parameter set can describe seconds in silicon and a few dozen ticks in simulation. All pins are plain levels. The block carries no data stream, so it has no valid/ready handshake.

Top module: `ref_qual_timer`

## Requirements
- R1: `ref_fail` is high exactly when at least one of the three filtered flags (single-period, coarse, fine) is high.
- R2: While the filtered single-period or coarse flag is high, `holdover_req` is high.
- R3: The fine-frequency flag alone never raises `holdover_req`, and it never adds failure time toward disqualification.
- R4: A filtered flag takes a new raw value only after the raw input has shown that value on HYST_TICKS consecutive tick cycles. The flip happens at the clock edge of the last of those ticks. A shorter excursion leaves the filtered flag unchanged.
- R5: On each tick where the filtered severe flag (single-period OR coarse) was already high before that edge, one failure tick is added. `disqualified` rises at the edge where the accumulated count reaches DISQ_TICKS.
- R6: A clean gap shorter than REQ_TICKS ticks does not clear the accumulated failure time. Repeated short episodes therefore reach disqualification.
- R7: REQ_TICKS consecutive ticks without a severe flag clear the accumulated count and drop `disqualified`. Any severe tick restarts the clean count.
- R8: `holdover_req` is the OR of the filtered severe flag and `disqualified`. It falls once both are low.
- R9: During and directly after reset, all outputs are low, the reference is qualified and all counts are zero.
- R10: Filters and counters change state only on cycles where `tick` is high. Raw inputs on other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base strobe |
| scm_fail_in | input | 1 | Raw single-period failure flag |
| cfm_fail_in | input | 1 | Raw coarse frequency failure flag |
| pfm_fail_in | input | 1 | Raw fine frequency failure flag |
| ref_fail | output | 1 | Filtered reference-fail status |
| holdover_req | output | 1 | Request for the loop to enter holdover |
| disqualified | output | 1 | Reference is currently not usable |

## Verification
Two events can land on the same edge. The persistence filter can release the severe flag at the same edge where the timer counts the last failure tick that it needs. At that edge `ref_fail` falls, `disqualified` rises and `holdover_req` must stay high without a gap. A directed case drives the single-period flag for exactly DISQ_TICKS ticks and then low for HYST_TICKS ticks straight after reset. It then checks all three outputs on that edge. Random stretches with irregular ticks also produce this overlap, and a per-tick model written from the requirements judges every cycle.

// File: rtl/ref_qual_pkg.sv
package ref_qual_pkg;
  localparam int NUM_MON = 3;

  typedef enum int {
    MON_SCM = 0,
    MON_CFM = 1,
    MON_PFM = 2
  } mon_idx_e;

  typedef struct packed {
    logic pfm;
    logic cfm;
    logic scm;
  } mon_flags_t;
endpackage

// File: rtl/persist_filter.sv
module persist_filter #(
  parameter int HYST_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic filt
);
  localparam int CW = (HYST_TICKS < 2) ? 1 : $clog2(HYST_TICKS);
  localparam logic [CW-1:0] LAST = CW'(HYST_TICKS - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt    <= 1'b0;
      run_cnt <= '0;
    end else if (tick) begin
      if (raw == filt) begin
        run_cnt <= '0;
      end else if (run_cnt == LAST) begin
        filt    <= raw;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  AST_FILT_HOLDS_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(filt)); // R10

  AST_FILT_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> (filt == $past(raw))); // R4
endmodule

// File: rtl/qual_timer.sv
module qual_timer #(
  parameter int DISQ_TICKS = 2500,
  parameter int REQ_TICKS  = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic severe,
  output logic disq
);
  localparam int AW = $clog2(DISQ_TICKS + 1);
  localparam int QW = $clog2(REQ_TICKS + 1);
  localparam logic [AW-1:0] ACC_LAST  = AW'(DISQ_TICKS - 1);
  localparam logic [AW-1:0] ACC_FULL  = AW'(DISQ_TICKS);
  localparam logic [QW-1:0] QUIET_END = QW'(REQ_TICKS - 1);

  logic [AW-1:0] acc_cnt;
  logic [QW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt   <= '0;
      quiet_cnt <= '0;
      disq      <= 1'b0;
    end else if (tick) begin
      if (severe) begin
        quiet_cnt <= '0;
        if (!disq) begin
          if (acc_cnt == ACC_LAST) begin
            acc_cnt <= ACC_FULL;
            disq    <= 1'b1;
          end else begin
            acc_cnt <= acc_cnt + 1'b1;
          end
        end
      end else if (quiet_cnt == QUIET_END) begin
        quiet_cnt <= '0;
        acc_cnt   <= '0;
        disq      <= 1'b0;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end
  end

  AST_ACC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cnt <= ACC_FULL); // R5

  AST_DISQ_NEEDS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disq) |-> ($past(severe) && $past(tick))); // R5

  AST_REQUAL_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disq) |-> (!$past(severe) && $past(tick))); // R7

  AST_FAIL_RESTARTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && severe) |=> (quiet_cnt == '0)); // R7

  AST_DISQ_HOLDS_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(disq)); // R10
endmodule

// File: rtl/ref_qual_timer.sv
module ref_qual_timer #(
  parameter int HYST_TICKS = 4,
  parameter int DISQ_TICKS = 2500,
  parameter int REQ_TICKS  = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic scm_fail_in,
  input  logic cfm_fail_in,
  input  logic pfm_fail_in,
  output logic ref_fail,
  output logic holdover_req,
  output logic disqualified
);
  import ref_qual_pkg::*;

  logic [NUM_MON-1:0] raw_vec;
  logic [NUM_MON-1:0] filt_vec;
  mon_flags_t         flags;
  logic               severe;

  assign raw_vec[MON_SCM] = scm_fail_in;
  assign raw_vec[MON_CFM] = cfm_fail_in;
  assign raw_vec[MON_PFM] = pfm_fail_in;

  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    persist_filter #(.HYST_TICKS(HYST_TICKS)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .raw  (raw_vec[g]),
      .filt (filt_vec[g])
    );
  end

  assign flags.scm = filt_vec[MON_SCM];
  assign flags.cfm = filt_vec[MON_CFM];
  assign flags.pfm = filt_vec[MON_PFM];

  assign severe = flags.scm | flags.cfm;

  qual_timer #(.DISQ_TICKS(DISQ_TICKS), .REQ_TICKS(REQ_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .severe(severe),
    .disq  (disqualified)
  );

  assign ref_fail     = flags.scm | flags.cfm | flags.pfm;
  assign holdover_req = severe | disqualified;

  AST_HOLD_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover_req && !disqualified) |-> ref_fail); // R2

  AST_DISQ_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    disqualified |-> holdover_req); // R8

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_n) |-> (!ref_fail && !holdover_req && !disqualified)); // R9
endmodule

// File: tb/sim_ref_qual_timer.sv
module sim_ref_qual_timer;
  localparam int HT = 3;
  localparam int DT = 12;
  localparam int RT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic scm = 1'b0, cfm = 1'b0, pfm = 1'b0;
  logic ref_fail, holdover_req, disqualified;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state, updated per tick from the requirements
  logic [2:0] m_filt;
  int         m_run [3];
  int         m_acc, m_quiet;
  logic       m_disq;

  always #5 clk = ~clk;

  ref_qual_timer #(.HYST_TICKS(HT), .DISQ_TICKS(DT), .REQ_TICKS(RT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .scm_fail_in(scm), .cfm_fail_in(cfm), .pfm_fail_in(pfm),
    .ref_fail(ref_fail), .holdover_req(holdover_req), .disqualified(disqualified)
  );

  function automatic logic exp_fail();
    return |m_filt;
  endfunction

  function automatic logic exp_hold();
    return m_filt[0] | m_filt[1] | m_disq;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_filt = 3'b000;
      for (int i = 0; i < 3; i++) m_run[i] = 0;
      m_acc = 0; m_quiet = 0; m_disq = 1'b0;
    end else if (tick) begin
      logic [2:0] rv;
      rv = {pfm, cfm, scm};
      // R5/R7: timer sees the filtered flags from before this edge
      if (m_filt[0] | m_filt[1]) begin
        m_quiet = 0;
        if (!m_disq) begin
          m_acc++;
          if (m_acc >= DT) m_disq = 1'b1;
        end
      end else begin
        m_quiet++;
        if (m_quiet >= RT) begin
          m_quiet = 0; m_acc = 0; m_disq = 1'b0;
        end
      end
      // R4: persistence filter
      for (int i = 0; i < 3; i++) begin
        if (rv[i] == m_filt[i]) m_run[i] = 0;
        else begin
          m_run[i]++;
          if (m_run[i] >= HT) begin
            m_filt[i] = rv[i];
            m_run[i] = 0;
          end
        end
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // one cycle: compare at negedge, then drive the next inputs
  task automatic cyc(input logic s, input logic c, input logic p, input logic t);
    @(negedge clk);
    if (rst_n) begin
      chk(ref_fail, exp_fail(), "R1 ref_fail");
      chk(holdover_req, exp_hold(), "R8 holdover_req");
      chk(disqualified, m_disq, "R5 disqualified");
    end
    scm = s; cfm = c; pfm = p; tick = t;
  endtask

  task automatic run(input int n, input logic s, input logic c, input logic p);
    for (int i = 0; i < n; i++) cyc(s, c, p, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; scm = 0; cfm = 0; pfm = 0; tick = 0;
    repeat (3) @(negedge clk);
    chk(ref_fail, 1'b0, "R9 ref_fail in reset");
    chk(holdover_req, 1'b0, "R9 holdover in reset");
    chk(disqualified, 1'b0, "R9 disq in reset");
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    cyc(0, 0, 0, 1);
    @(negedge clk);
    chk(disqualified, 1'b0, "R9 qualified after reset");
    // R4: short fine-frequency excursion ignored
    run(HT - 1, 0, 0, 1);
    run(HT + 1, 0, 0, 0);
    @(negedge clk);
    chk(ref_fail, 1'b0, "R4 short pulse ignored");
    // R1/R3: fine flag sets status but not holdover
    run(HT + 3, 0, 0, 1);
    @(negedge clk);
    chk(ref_fail, 1'b1, "R1 fine flag sets status");
    chk(holdover_req, 1'b0, "R3 fine flag no holdover");
    run(HT + 1, 0, 0, 0);
    // R10: raw high without ticks has no effect
    for (int i = 0; i < 30; i++) cyc(1, 1, 1, 0);
    @(negedge clk);
    chk(ref_fail, 1'b0, "R10 no tick no change");
    chk(holdover_req, 1'b0, "R10 holdover stable");
    // R2/R6: two bursts of 9 counted ticks each, short gap between
    run(HT + 6, 1, 0, 0);
    @(negedge clk);
    chk(holdover_req, 1'b1, "R2 single-period holdover");
    run(HT + 10, 0, 0, 0);
    @(negedge clk);
    chk(disqualified, 1'b0, "R5 below threshold");
    run(HT + 6, 0, 1, 0);
    run(HT + 2, 0, 0, 0);
    @(negedge clk);
    chk(disqualified, 1'b1, "R6 accumulated bursts disqualify");
    chk(holdover_req, 1'b1, "R8 holdover while disqualified");
    // R7: long clean interval requalifies
    run(RT + 2, 0, 0, 0);
    @(negedge clk);
    chk(disqualified, 1'b0, "R7 requalified");
    chk(holdover_req, 1'b0, "R8 holdover released");
    // coincidence: filter release on the edge the threshold is reached
    do_reset();
    run(DT, 1, 0, 0);
    run(HT, 0, 0, 0);
    @(negedge clk);
    chk(ref_fail, 1'b0, "R1 released at threshold edge");
    chk(disqualified, 1'b1, "R5 disq at release edge");
    chk(holdover_req, 1'b1, "R8 holdover continuous");
    run(RT + 1, 0, 0, 0);
    // random stretches
    for (int seg = 0; seg < 400; seg++) begin
      int len;
      logic s, c, p;
      len = 1 + ($urandom % 30);
      s = ($urandom % 3) == 0;
      c = ($urandom % 4) == 0;
      p = ($urandom % 2) == 0;
      for (int k = 0; k < len; k++)
        cyc(s, c, p, ($urandom % 4) != 0);
      if (seg % 25 == 24) run(RT + HT + 2, 0, 0, 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule